// File: doc/BRIEF.md
# Gated Lock Filter

This block sits beside a clock generator and cleans up its lock indication. While the loop is still acquiring, the raw lock flag can chatter. The block brings that flag into the reference clock domain and passes it on as the ungated lock output. It also drives a gated lock output, which rises only after the synchronized flag has stayed high for a programmable number of reference cycles. The hold value is up to 20 bits wide, so the wait can be as long as about one million cycles.

An asynchronous reset and an active-high enable both return the block to the out-of-lock state and restart the count. A hold value of zero behaves as a hold of one. When self-reset is enabled, losing lock after the gated output has been high issues one fixed four-cycle request to reset the clock generator.

Top module: `lock_gate_filter`

## Requirements
- R1: While `rst_async` is high, `lock_ungated`, `lock_gated` and `pll_reset_req` are low, immediately and without waiting for a clock edge.
- R2: `lock_ungated` equals `lock_raw` as sampled two rising edges of `clk_ref` earlier, while the block is enabled.
- R3: `lock_gated` goes high exactly `hold_cycles` reference cycles after `lock_ungated` goes high. It then stays high for as long as `lock_ungated` stays high.
- R4: `lock_gated` falls in the same cycle as `lock_ungated`, and the next lock acquisition waits the full hold count again.
- R5: A `hold_cycles` value of 0 gives the same timing as a value of 1.
- R6: After a rising edge of `clk_ref` with `enable` low, all three outputs are low and the hold count restarts from zero.
- R7: When `self_reset_en` is high and `lock_ungated` falls after `lock_gated` has been high, `pll_reset_req` goes high one cycle after the fall and stays high for exactly 4 cycles.
- R8: No reset request is issued when `self_reset_en` is low, or when lock is lost before `lock_gated` has risen during that lock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_async | input | 1 | Asynchronous reset, active high |
| enable | input | 1 | Block enable; low clears all state |
| lock_raw | input | 1 | Unsynchronized lock flag from the detector |
| hold_cycles | input | 20 | Reference cycles to hold gated lock low (0 acts as 1) |
| self_reset_en | input | 1 | Allow a reset request on loss of lock |
| lock_ungated | output | 1 | Synchronized raw lock |
| lock_gated | output | 1 | Filtered lock |
| pll_reset_req | output | 1 | Four-cycle reset request to the clock generator |

## Verification
A wrong hold count shows up at the first lock acquisition: the gated output rises one or more cycles early or late relative to the ungated output. A stale count, or a stale armed state, shows up only at the next lock episode. It appears either as a gated rise with no full wait, or as a reset request with no lock to justify it. For this reason the stimulus chains short and aborted lock episodes one after another. A fault in the synchronizer delay shows up at once on the ungated output, at every toggle of the raw flag.

// File: rtl/lock_gate_filter.sv
module lock_gate_filter #(
  parameter int CNT_W     = 20,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk_ref,
  input  logic             rst_async,
  input  logic             enable,
  input  logic             lock_raw,
  input  logic [CNT_W-1:0] hold_cycles,
  input  logic             self_reset_en,
  output logic             lock_ungated,
  output logic             lock_gated,
  output logic             pll_reset_req
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic             s1, s2, s3, armed;
  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    req_cnt;

  wire [CNT_W-1:0] hold_eff = (hold_cycles == '0) ? CNT_W'(1) : hold_cycles;
  wire             lost     = s3 & ~s2;

  always_ff @(posedge clk_ref or posedge rst_async) begin
    if (rst_async) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0; armed <= 1'b0;
      cnt <= '0; req_cnt <= '0;
    end else if (!enable) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0; armed <= 1'b0;
      cnt <= '0; req_cnt <= '0;
    end else begin
      s1 <= lock_raw;
      s2 <= s1;
      s3 <= s2;
      if (!s2)                 cnt <= '0;
      else if (cnt < hold_eff) cnt <= cnt + CNT_W'(1);
      armed <= (armed | lock_gated) & ~lost;
      if (lost && armed && self_reset_en) req_cnt <= PW'(PULSE_LEN);
      else if (req_cnt != '0)             req_cnt <= req_cnt - PW'(1);
    end
  end

  assign lock_ungated  = s2;
  assign lock_gated    = s2 & (cnt >= hold_eff);
  assign pll_reset_req = (req_cnt != '0);

  AST_DISABLE_CLEARS: assert property (@(posedge clk_ref) disable iff (rst_async)
    !enable |=> (!lock_ungated && !lock_gated && !pll_reset_req)); // R6
  AST_GATED_AFTER_UNGATED: assert property (@(posedge clk_ref) disable iff (rst_async)
    $rose(lock_gated) |-> $past(lock_ungated)); // R3
  AST_REQ_HOLDS: assert property (@(posedge clk_ref) disable iff (rst_async)
    ($rose(pll_reset_req) && enable) |=> pll_reset_req); // R7
  AST_REQ_NEEDS_LOSS: assert property (@(posedge clk_ref) disable iff (rst_async)
    $rose(pll_reset_req) |-> ($past(self_reset_en) && !$past(lock_ungated))); // R8
endmodule

// File: tb/lock_gate_filter_bench.sv
module lock_gate_filter_bench;
  logic clk = 0, rst = 1, en = 0, raw = 0, sre = 0;
  logic [19:0] hold = 20'd5;
  logic ung, gat, req;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lock_gate_filter u_lock_gate_filter (
    .clk_ref(clk), .rst_async(rst), .enable(en), .lock_raw(raw),
    .hold_cycles(hold), .self_reset_en(sre),
    .lock_ungated(ung), .lock_gated(gat), .pll_reset_req(req));

  // behavioural reference: delay line of samples, run length, pending request
  int p1, p2, lastu, run, pulse, armed;
  always @(posedge clk or posedge rst) begin
    if (rst || !en) begin
      p1 = 0; p2 = 0; lastu = 0; run = 0; pulse = 0; armed = 0;
    end else begin
      int heff, u0, g0, fall;
      heff = (hold == 0) ? 1 : int'(hold);
      u0 = p2; g0 = (u0 != 0 && run >= heff) ? 1 : 0;
      fall = (lastu != 0 && u0 == 0) ? 1 : 0;
      if (fall != 0 && armed != 0 && sre) pulse = 4;
      else if (pulse > 0) pulse = pulse - 1;
      armed = ((armed != 0 || g0 != 0) && fall == 0) ? 1 : 0;
      run = (u0 != 0) ? run + 1 : 0;
      lastu = u0; p2 = p1; p1 = raw ? 1 : 0;
    end
  end

  function automatic logic m_gated();
    int heff = (hold == 0) ? 1 : int'(hold);
    return (p2 != 0 && run >= heff);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(ung, p2 != 0, "R2 ungated");
      check(gat, m_gated(), "R3 R4 gated");
      check(req, pulse > 0, "R7 R8 request");
    end
  endtask

  task automatic measure_hold(input int exp, input string tag);
    int n = 0;
    raw = 1;
    while (!ung) cyc(1);
    while (!gat && n < 1000) begin cyc(1); n++; end
    checks++;
    if (n != exp) begin errors++; $display("FAIL %s hold actual=%0d expected=%0d", tag, n, exp); end
  endtask

  task automatic count_req(input int exp, input string tag);
    int n = 0;
    raw = 0;
    for (int i = 0; i < 12; i++) begin cyc(1); if (req) n++; end
    checks++;
    if (n != exp) begin errors++; $display("FAIL %s req cycles actual=%0d expected=%0d", tag, n, exp); end
  endtask

  initial begin
    #1;
    checks++; if (ung || gat || req) begin errors++; $display("FAIL R1 reset actual=%0b%0b%0b expected=000", ung, gat, req); end
    repeat (3) @(negedge clk);
    rst = 0; en = 1; sre = 1;
    cyc(2);
    measure_hold(5, "R3");
    cyc(6);
    count_req(4, "R7");
    sre = 0; measure_hold(5, "R3 R4 reacquire");
    count_req(0, "R8 self-reset off");
    sre = 1; raw = 1; cyc(4); count_req(0, "R8 no gated lock");
    hold = 20'd0; measure_hold(1, "R5 zero");
    hold = 20'd1; raw = 0; cyc(4); measure_hold(1, "R5 one");
    en = 0; cyc(1);
    checks++; if (ung || gat || req) begin errors++; $display("FAIL R6 disable actual=%0b%0b%0b expected=000", ung, gat, req); end
    en = 1; hold = 20'd7; measure_hold(7, "R6 restart");
    for (int i = 0; i < 40; i++) begin raw = ((i * 7) % 5) < 2; cyc(1); end
    hold = 20'd300; raw = 0; cyc(4); measure_hold(300, "R3 long");
    @(negedge clk); rst = 1; #1;
    checks++; if (ung || gat || req) begin errors++; $display("FAIL R1 async actual=%0b%0b%0b expected=000", ung, gat, req); end
    cyc(2); rst = 0; raw = 0; cyc(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule